// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

A chain of identical 4-bit binary counting stages that share one rising-edge clock. Each stage can be preset from a parallel data bus, can count up or down, or can hold. Every state bit updates on the same clock edge, so no bit is clocked by a neighbour. Load is synchronous, active-low, and overrides every other control. Counting needs both active-low enables, P and T, to be LOW. A direction input selects increment or decrement.

Each stage drives an active-low carry. The carry is combinational from the stage's own count, the direction and its T enable. It goes LOW only while T is LOW and the stage sits at its terminal value: all ones when counting up, all zeros when counting down. Stage k's carry drives stage k+1's T enable, and all stages share P. The chain therefore behaves as one wide counter that wraps modulo 2^(4·N). The carry of the last stage is available for chaining further. An asynchronous active-low reset, released synchronously inside the block, clears the count to zero.

Top module: `cascade_updown_counter`

## Requirements
- R1: After reset is released, and before any load or count, the count is zero and the carry output is HIGH while enable T is HIGH.
- R2: When load_n is LOW at a rising edge, the count equals the data bus after that edge, whatever the enables and the direction are.
- R3: When load_n is HIGH and either en_p_n or en_t_n is HIGH at a rising edge, the count does not change on that edge.
- R4: When load_n is HIGH, en_p_n and en_t_n are both LOW and dir_up is 1, the count increments by one on the edge, and wraps from all ones to zero.
- R5: When load_n is HIGH, en_p_n and en_t_n are both LOW and dir_up is 0, the count decrements by one on the edge, and wraps from zero to all ones.
- R6: With dir_up at 1, carry_n is LOW exactly when en_t_n is LOW and the whole count is all ones. Otherwise it is HIGH.
- R7: With dir_up at 0, carry_n is LOW exactly when en_t_n is LOW and the whole count is zero. Otherwise it is HIGH.
- R8: The chained count matches a single wide counter of the full width under any mix of loads, holds, up counts and down counts.
- R9: carry_n follows changes on en_t_n and dir_up within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_n | input | 1 | Active-low synchronous parallel load |
| data | input | STAGE_BITS*NUM_STAGES | Preset value |
| en_p_n | input | 1 | Active-low count enable shared by all stages |
| en_t_n | input | 1 | Active-low count enable of the first stage; also gates the carry |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| count | output | STAGE_BITS*NUM_STAGES | Current count |
| carry_n | output | 1 | Active-low carry of the last stage |

## Verification
Every change to the count comes from one register stage. The bench drives its inputs on the falling edge and compares the count one time unit after the next rising edge against an arithmetic model of the full width. The carry has no register, so the bench checks it one time unit after the inputs change, before any clock edge. It also toggles T and direction between edges to show that the carry responds at once. After the reset input rises, the count stays cleared for two edges while the release passes through the synchronizer. The bench waits out those edges before the first functional check, and the checker module applies the same allowance.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } udc_op_e;

  localparam int unsigned RST_SYNC_DEPTH = 2;

endpackage

// File: rtl/udc_rst_sync.sv
module udc_rst_sync #(
  parameter int unsigned DEPTH = udc_pkg::RST_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[DEPTH-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[DEPTH-1];

endmodule

// File: rtl/udc_carry_dec.sv
module udc_carry_dec #(
  parameter int unsigned BITS = 4
) (
  input  logic [BITS-1:0] q,
  input  logic            dir_up,
  input  logic            en_t_n,
  output logic            carry_n
);

  logic at_top;
  logic at_bottom;
  logic terminal;

  always_comb begin
    at_top    = &q;
    at_bottom = ~|q;
    terminal  = dir_up ? at_top : at_bottom;
    carry_n   = ~(terminal & ~en_t_n);
  end

endmodule

// File: rtl/udc_stage.sv
module udc_stage
  import udc_pkg::*;
#(
  parameter int unsigned BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_n,
  input  logic [BITS-1:0] d,
  input  logic            en_p_n,
  input  logic            en_t_n,
  input  logic            dir_up,
  output logic [BITS-1:0] q,
  output logic            carry_n
);

  localparam logic [BITS-1:0] ONE = BITS'(1);

  udc_op_e         op;
  logic [BITS-1:0] q_r;
  logic [BITS-1:0] q_nxt;
  logic            q_en;

  // operation select: load first, then the joint enable, then direction
  always_comb begin
    if (!load_n) begin
      op = OP_LOAD;
    end else if (!en_p_n && !en_t_n) begin
      op = dir_up ? OP_INC : OP_DEC;
    end else begin
      op = OP_HOLD;
    end
  end

  always_comb begin
    unique case (op)
      OP_LOAD: q_nxt = d;
      OP_INC:  q_nxt = q_r + ONE;
      OP_DEC:  q_nxt = q_r - ONE;
      default: q_nxt = q_r;
    endcase
    q_en = (op != OP_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (q_en) begin
      q_r <= q_nxt;
    end
  end

  udc_carry_dec #(.BITS(BITS)) u_carry (
    .q       (q_r),
    .dir_up  (dir_up),
    .en_t_n  (en_t_n),
    .carry_n (carry_n)
  );

  assign q = q_r;

endmodule

// File: rtl/cascade_updown_counter.sv
module cascade_updown_counter #(
  parameter int unsigned STAGE_BITS = 4,
  parameter int unsigned NUM_STAGES = 3,
  localparam int unsigned W = STAGE_BITS * NUM_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] data,
  input  logic         en_p_n,
  input  logic         en_t_n,
  input  logic         dir_up,
  output logic [W-1:0] count,
  output logic         carry_n
);

  logic                rst_int_n;
  logic [NUM_STAGES:0] t_link_n;

  udc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign t_link_n[0] = en_t_n;

  // stage k is enabled through T by the carry of stage k-1
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    udc_stage #(.BITS(STAGE_BITS)) u_stage (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .load_n  (load_n),
      .d       (data[k*STAGE_BITS +: STAGE_BITS]),
      .en_p_n  (en_p_n),
      .en_t_n  (t_link_n[k]),
      .dir_up  (dir_up),
      .q       (count[k*STAGE_BITS +: STAGE_BITS]),
      .carry_n (t_link_n[k+1])
    );
  end

  assign carry_n = t_link_n[NUM_STAGES];

endmodule

// File: rtl/udc_chain_chk.sv
module udc_chain_chk #(
  parameter int unsigned STAGE_BITS = 4,
  parameter int unsigned NUM_STAGES = 3,
  localparam int unsigned W = STAGE_BITS * NUM_STAGES
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic [W-1:0] data,
  input logic         en_p_n,
  input logic         en_t_n,
  input logic         dir_up,
  input logic [W-1:0] count,
  input logic         carry_n
);

  localparam logic [W-1:0] ONE = W'(1);

  // wait out the internal reset release before checking edges
  logic [1:0] settle_q;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (settle_q != 2'd3) begin
      settle_q <= settle_q + 2'd1;
    end
  end

  assign settled = (settle_q == 2'd3);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !load_n) |=> (count == $past(data)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && load_n && (en_p_n || en_t_n)) |=> $stable(count));

  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && load_n && !en_p_n && !en_t_n && dir_up)
      |=> (count == $past(count) + ONE));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && load_n && !en_p_n && !en_t_n && !dir_up)
      |=> (count == $past(count) - ONE));

  assert_carry_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && dir_up) |-> (carry_n == !(!en_t_n && (&count))));

  assert_carry_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !dir_up) |-> (carry_n == !(!en_t_n && !(|count))));

endmodule

bind cascade_updown_counter udc_chain_chk #(
  .STAGE_BITS(STAGE_BITS),
  .NUM_STAGES(NUM_STAGES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_n  (load_n),
  .data    (data),
  .en_p_n  (en_p_n),
  .en_t_n  (en_t_n),
  .dir_up  (dir_up),
  .count   (count),
  .carry_n (carry_n)
);

// File: tb/cascade_updown_counter_test.sv
`timescale 1ns/1ps
module cascade_updown_counter_test;

  localparam int unsigned SB = 4;
  localparam int unsigned NS = 3;
  localparam int unsigned W  = SB * NS;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_n;
  logic [W-1:0] data;
  logic         en_p_n;
  logic         en_t_n;
  logic         dir_up;
  logic [W-1:0] count;
  logic         carry_n;

  int unsigned  nchk  = 0;
  int unsigned  nfail = 0;
  logic [W-1:0] model_q;
  logic [15:0]  lfsr;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  cascade_updown_counter #(.STAGE_BITS(SB), .NUM_STAGES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .data(data),
    .en_p_n(en_p_n), .en_t_n(en_t_n), .dir_up(dir_up),
    .count(count), .carry_n(carry_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_carry(input logic t, input logic dir, input logic [W-1:0] q);
    return !(!t && (dir ? (q == ALL1) : (q == '0)));
  endfunction

  // drive on the falling edge, check carry before the edge, check count after it
  task automatic step(input logic ld, input logic [W-1:0] d, input logic p,
                      input logic t, input logic dir, input string req);
    @(negedge clk);
    load_n = ld; data = d; en_p_n = p; en_t_n = t; dir_up = dir;
    #1;
    chk(dir ? "R6 carry" : "R7 carry", W'(carry_n), W'(exp_carry(t, dir, model_q)));
    @(posedge clk);
    if (!ld)            model_q = d;
    else if (!p && !t)  model_q = dir ? model_q + W'(1) : model_q - W'(1);
    #1;
    chk(req, count, model_q);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; data = '0; en_p_n = 1'b1; en_t_n = 1'b1; dir_up = 1'b1;
    model_q = '0;
    lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 count", count, '0);
    chk("R1 carry", W'(carry_n), W'(1'b1));

    // R2: load wins over every enable/direction combination
    step(1'b0, 12'hABC, 1'b1, 1'b1, 1'b0, "R2 load enables high");
    step(1'b0, 12'h35A, 1'b0, 1'b0, 1'b1, "R2 load over count up");
    step(1'b0, 12'h0F0, 1'b0, 1'b0, 1'b0, "R2 load over count down");

    // R3: either enable HIGH holds
    step(1'b1, 12'hFFF, 1'b1, 1'b0, 1'b1, "R3 hold P high");
    step(1'b1, 12'hFFF, 1'b0, 1'b1, 1'b0, "R3 hold T high");
    step(1'b1, 12'h000, 1'b1, 1'b1, 1'b1, "R3 hold both high");

    // R4/R6: full up sweep from zero with wrap
    step(1'b0, 12'h000, 1'b1, 1'b1, 1'b1, "R2 load zero");
    for (int i = 0; i < (1 << W) + 1; i++)
      step(1'b1, '0, 1'b0, 1'b0, 1'b1, "R4 up sweep");

    // R5/R7: full down sweep through zero with wrap
    step(1'b0, 12'h005, 1'b1, 1'b1, 1'b0, "R2 load five");
    for (int i = 0; i < (1 << W) + 8; i++)
      step(1'b1, '0, 1'b0, 1'b0, 1'b0, "R5 down sweep");

    // R9: carry responds to T and direction without a clock edge
    step(1'b0, ALL1, 1'b1, 1'b1, 1'b1, "R2 load all ones");
    @(negedge clk);
    load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b0; dir_up = 1'b1; #1;
    chk("R9 carry T low up at ones", W'(carry_n), W'(1'b0));
    dir_up = 1'b0; #1;
    chk("R9 carry dir down at ones", W'(carry_n), W'(1'b1));
    dir_up = 1'b1; #1;
    chk("R9 carry dir back up", W'(carry_n), W'(1'b0));
    en_t_n = 1'b1; #1;
    chk("R9 carry T high", W'(carry_n), W'(1'b1));
    @(posedge clk); #1;
    chk("R3 hold during R9 probe", count, ALL1);

    // R8: mixed traffic against the wide model
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'd0, W'({lfsr, lfsr} >> 5),
           lfsr[6:5] == 2'd3, lfsr[8:7] == 2'd3, lfsr[9], "R8 mixed");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule